// File: doc/BRIEF.md
# Banked Scratchpad Read Conflict Arbiter

This block sits between a group of 32 read lanes and a scratchpad made of 32 banks, each one 32-bit word wide. A request carries, for every lane, an active bit, a word address and a flag for a single-word or a double-word read. The bank a word sits in is its address taken modulo 32. A double-word read at word `a` takes bank `a mod 32` with word `a` and bank `(a+1) mod 32` with word `a+1`. When two pending lanes need the same bank with different words, they are served in different rounds. Lanes that want the same word in a bank share that access as a broadcast.

After it accepts a request, the arbiter runs one round per cycle. In each round it drives per-bank enables and word addresses, a mask of the lanes served, and for each served lane the bank its data starts in. Each bank gives its slot to the word of the lowest-numbered pending lane that touches it. Every pending lane whose words all match the slots of its banks is served in that round. So the lowest pending lane is always served. A stride-1 pattern finishes in one round and 32 distinct words in one bank take 32 rounds. In the last round the arbiter raises `done` and reports how many rounds the request used. It takes a new request on the next cycle.

Top module: `sbank_arbiter`

## Requirements
- R1: After reset, `reqReady` is 1 and `roundValid`, `done`, `bankEn` and `laneServed` are all 0.
- R2: A lane's bank is its word address modulo 32. Thirty-two single-word lanes where lane i reads a word in bank i finish in one round with all 32 bank enables set, and `bankAddr` of bank i holds lane i's word.
- R3: Thirty-two active lanes that read distinct words in one bank take 32 rounds, with exactly lane k served in round k (counting from 0).
- R4: Lanes reading an identical word are served together in one round, and only that word's bank is enabled.
- R5: A double-word read at word a enables bank a mod 32 with word a and bank (a+1) mod 32 with word a+1. From bank 31 it wraps to bank 0.
- R6: A single-word lane whose word equals the upper word of a double-word lane shares that lane's round. A lane that needs an occupied bank with a different word waits for a later round.
- R7: In each round, every bank carries the word of the lowest-numbered pending lane that touches it. All pending lanes that match every bank they touch are served in that round.
- R8: A double-word lane is served only in a round in which both of its banks carry its words. It is not served when only one of them is free.
- R9: In each round, `laneServed` marks the lanes served, and each served lane's field in `laneBank` (5 bits per lane, lane l at bits 5l+4..5l) holds its first bank. Over one request each active lane is served exactly once.
- R10: `done` is high for one cycle, in the cycle of the last round. In that cycle `roundCount` equals the number of rounds, and `reqReady` is 1 in the next cycle.
- R11: `reqStart` while a request is in progress has no effect. No extra rounds follow the current request.
- R12: Inactive lanes are never served. A request with no active lane raises `done` with `roundCount` 0 and produces no round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqStart | input | 1 | Offers a request; taken when `reqReady` is 1 |
| reqReady | output | 1 | Arbiter idle and able to take a request |
| reqActive | input | 32 | Active bit per lane |
| reqWide | input | 32 | Per lane: 1 for a double-word read, 0 for a single word |
| reqAddr | input | 320 | Word address per lane, lane l at bits 10l+9..10l |
| bankEn | output | 32 | Bank enables for the current round |
| bankAddr | output | 320 | Word address per bank, bank b at bits 10b+9..10b; 0 when not enabled |
| laneServed | output | 32 | Lanes served in the current round |
| laneBank | output | 160 | First bank of each served lane, lane l at bits 5l+4..5l |
| roundValid | output | 1 | A round is being issued this cycle |
| done | output | 1 | Last round of the request (or empty request finished) |
| roundCount | output | 6 | Rounds used by the request, valid with `done` |

## Verification
The bound checker tracks which lanes were accepted and which have been served. On every cycle it enforces that only accepted lanes are served, that no lane is served twice, and that the lowest pending lane is in each round's mask. It also checks that `done` comes only once every accepted lane is served and returns the arbiter to ready, and that nothing is issued while idle. The exact grouping into rounds can only be shown by the bench's scenarios: the stride-1, same-bank, broadcast, wrapping double-word and blocked double-word cases, plus the stray start while busy. For these, a reference model of the grant rule supplies the expected masks and round counts.

// File: rtl/sbank_pkg.sv
package sbank_pkg;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobe_t;

endpackage

// File: rtl/sbank_datapath.sv
module sbank_datapath
  import sbank_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 10,
  localparam int BW   = $clog2(BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           ctl,
  input  logic [LANES-1:0]     reqActive,
  input  logic [LANES-1:0]     reqWide,
  input  logic [LANES*AW-1:0]  reqAddr,
  output logic                 anyPending,
  output logic                 restZero,
  output logic [BANKS-1:0]     bankEn,
  output logic [BANKS*AW-1:0]  bankAddr,
  output logic [LANES-1:0]     laneServed,
  output logic [LANES*BW-1:0]  laneBank
);

  logic [LANES-1:0] pendQ;
  logic [LANES-1:0] wideQ;
  logic [AW-1:0]    addrQ   [LANES];
  logic [BW-1:0]    baseOf  [LANES];
  logic [BW-1:0]    nextOf  [LANES];
  logic [AW-1:0]    hiWord  [LANES];
  logic [AW-1:0]    slotWord[BANKS];
  logic [LANES-1:0] servedC;
  logic [BANKS-1:0] bankEnC;

  // Per-lane bank footprint
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      baseOf[l] = addrQ[l][BW-1:0];
      nextOf[l] = baseOf[l] + 1'b1;
      hiWord[l] = addrQ[l] + 1'b1;
    end
  end

  // Each bank keeps the word of its lowest-numbered pending lane
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      slotWord[b] = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pendQ[l]) begin
          if (baseOf[l] == BW'(b)) begin
            slotWord[b] = addrQ[l];
          end else if (wideQ[l] && nextOf[l] == BW'(b)) begin
            slotWord[b] = hiWord[l];
          end
        end
      end
    end
  end

  // A lane is served when every bank it needs carries its word
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      servedC[l] = pendQ[l]
                && (slotWord[baseOf[l]] == addrQ[l])
                && (!wideQ[l] || slotWord[nextOf[l]] == hiWord[l]);
    end
  end

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bankEnC[b] = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (servedC[l] && (baseOf[l] == BW'(b) || (wideQ[l] && nextOf[l] == BW'(b)))) begin
          bankEnC[b] = 1'b1;
        end
      end
    end
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bankOut
      assign bankAddr[b*AW +: AW] = bankEnC[b] ? slotWord[b] : '0;
    end
    for (genvar l = 0; l < LANES; l++) begin : g_laneOut
      assign laneBank[l*BW +: BW] = servedC[l] ? baseOf[l] : '0;
    end
  endgenerate

  assign bankEn     = bankEnC;
  assign laneServed = servedC;
  assign anyPending = |pendQ;
  assign restZero   = ((pendQ & ~servedC) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      wideQ <= '0;
      for (int l = 0; l < LANES; l++) addrQ[l] <= '0;
    end else if (ctl.load) begin
      pendQ <= reqActive;
      wideQ <= reqWide;
      for (int l = 0; l < LANES; l++) addrQ[l] <= reqAddr[l*AW +: AW];
    end else if (ctl.step) begin
      pendQ <= pendQ & ~servedC;
    end
  end

endmodule

// File: rtl/sbank_control.sv
module sbank_control
  import sbank_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqStart,
  input  logic          anyPending,
  input  logic          restZero,
  output ctlStrobe_t    ctl,
  output logic          reqReady,
  output logic          roundValid,
  output logic          done,
  output logic [CW-1:0] roundCount
);

  phase_t        stateQ;
  logic [CW-1:0] cntQ;
  logic          running;

  assign running = (stateQ == PH_RUN);

  always_comb begin
    ctl        = '0;
    ctl.load   = !running && reqStart;
    ctl.step   = running;
    reqReady   = !running;
    roundValid = running && anyPending;
    done       = running && restZero;
    roundCount = cntQ + CW'(anyPending);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PH_IDLE;
      cntQ   <= '0;
    end else begin
      case (stateQ)
        PH_IDLE: if (ctl.load) begin
          stateQ <= PH_RUN;
          cntQ   <= '0;
        end
        PH_RUN: begin
          cntQ <= cntQ + 1'b1;
          if (restZero) stateQ <= PH_IDLE;
        end
        default: stateQ <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbank_arbiter.sv
module sbank_arbiter
  import sbank_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 10,
  localparam int BW   = $clog2(BANKS),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqStart,
  output logic                reqReady,
  input  logic [LANES-1:0]    reqActive,
  input  logic [LANES-1:0]    reqWide,
  input  logic [LANES*AW-1:0] reqAddr,
  output logic [BANKS-1:0]    bankEn,
  output logic [BANKS*AW-1:0] bankAddr,
  output logic [LANES-1:0]    laneServed,
  output logic [LANES*BW-1:0] laneBank,
  output logic                roundValid,
  output logic                done,
  output logic [CW-1:0]       roundCount
);

  ctlStrobe_t ctl;
  logic       anyPending;
  logic       restZero;

  sbank_control #(.CW(CW)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqStart   (reqStart),
    .anyPending (anyPending),
    .restZero   (restZero),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .roundValid (roundValid),
    .done       (done),
    .roundCount (roundCount)
  );

  sbank_datapath #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqActive  (reqActive),
    .reqWide    (reqWide),
    .reqAddr    (reqAddr),
    .anyPending (anyPending),
    .restZero   (restZero),
    .bankEn     (bankEn),
    .bankAddr   (bankAddr),
    .laneServed (laneServed),
    .laneBank   (laneBank)
  );

endmodule

// File: rtl/sbank_checker.sv
module sbank_checker #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int CW    = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqStart,
  input logic             reqReady,
  input logic [LANES-1:0] reqActive,
  input logic [BANKS-1:0] bankEn,
  input logic [LANES-1:0] laneServed,
  input logic             roundValid,
  input logic             done,
  input logic [CW-1:0]    roundCount
);

  logic [LANES-1:0] actQ;
  logic [LANES-1:0] seenQ;
  logic [LANES-1:0] pendNow;
  logic [LANES-1:0] lowest;

  assign pendNow = actQ & ~seenQ;
  assign lowest  = pendNow & (~pendNow + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ  <= '0;
      seenQ <= '0;
    end else if (reqStart && reqReady) begin
      actQ  <= reqActive;
      seenQ <= '0;
    end else if (roundValid) begin
      seenQ <= seenQ | laneServed;
    end
  end

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady); // R10

  AST_ALL_SERVED_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((seenQ | laneServed) == actQ)); // R10

  AST_NO_ROUND_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!roundValid && bankEn == '0 && laneServed == '0)); // R11

  AST_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    roundValid |-> ((laneServed & ~actQ) == '0)); // R12

  AST_SERVED_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    roundValid |-> ((laneServed & seenQ) == '0)); // R9

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    roundValid |-> ((laneServed & lowest) != '0)); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (roundCount <= CW'(LANES))); // R3

endmodule

bind sbank_arbiter sbank_checker #(.LANES(LANES), .BANKS(BANKS), .CW(CW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqStart   (reqStart),
  .reqReady   (reqReady),
  .reqActive  (reqActive),
  .bankEn     (bankEn),
  .laneServed (laneServed),
  .roundValid (roundValid),
  .done       (done),
  .roundCount (roundCount)
);

// File: tb/sbank_arbiter_test.sv
module sbank_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int AW = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqStart = 1'b0;
  logic            reqReady;
  logic [NL-1:0]   reqActive;
  logic [NL-1:0]   reqWide;
  logic [NL*AW-1:0] reqAddr;
  logic [NL-1:0]   bankEn;
  logic [NL*AW-1:0] bankAddr;
  logic [NL-1:0]   laneServed;
  logic [NL*5-1:0] laneBank;
  logic            roundValid;
  logic            done;
  logic [5:0]      roundCount;

  logic [AW-1:0] tAddr [NL];
  logic [NL-1:0] tAct  = '0;
  logic [NL-1:0] tWide = '0;
  logic [AW-1:0] mAddr [NL];
  logic [NL-1:0] mWide;

  logic [NL-1:0]    expMask [0:NL];
  logic [NL-1:0]    gotMask [0:NL];
  logic [NL-1:0]    gotEn   [0:NL];
  logic [NL*AW-1:0] gotBA   [0:NL];
  int expCountQ[$];
  int rIdx = 0;
  bit finished = 0;
  bit doneLast = 0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int l = 0; l < NL; l++) reqAddr[l*AW +: AW] = tAddr[l];
  end
  assign reqActive = tAct;
  assign reqWide   = tWide;

  sbank_arbiter uut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqReady(reqReady),
    .reqActive(reqActive), .reqWide(reqWide), .reqAddr(reqAddr),
    .bankEn(bankEn), .bankAddr(bankAddr), .laneServed(laneServed),
    .laneBank(laneBank), .roundValid(roundValid), .done(done),
    .roundCount(roundCount)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model of the grant rule, built from the requirements
  task automatic modelRun(output int n);
    logic [NL-1:0] pend;
    logic [AW-1:0] slot [NL];
    logic [NL-1:0] srv;
    pend = tAct;
    n = 0;
    for (int l = 0; l < NL; l++) mAddr[l] = tAddr[l];
    mWide = tWide;
    while (pend != '0) begin
      for (int b = 0; b < NL; b++) begin
        slot[b] = '0;
        for (int l = NL - 1; l >= 0; l--) begin
          if (pend[l]) begin
            if (int'(mAddr[l][4:0]) == b) slot[b] = mAddr[l];
            else if (mWide[l] && int'(5'(mAddr[l][4:0] + 5'd1)) == b) slot[b] = mAddr[l] + 1'b1;
          end
        end
      end
      for (int l = 0; l < NL; l++) begin
        srv[l] = pend[l] && slot[mAddr[l][4:0]] == mAddr[l]
              && (!mWide[l] || slot[5'(mAddr[l][4:0] + 5'd1)] == AW'(mAddr[l] + 1'b1));
      end
      expMask[n] = srv;
      pend = pend & ~srv;
      n++;
    end
  endtask

  // Driver: pushes the expected round count and launches one request
  task automatic runReq(input bit strayStart);
    int n;
    modelRun(n);
    expCountQ.push_back(n);
    finished = 0;
    @(negedge clk);
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    if (strayStart) begin
      @(negedge clk);
      tAct = '1;
      tWide = '0;
      for (int l = 0; l < NL; l++) tAddr[l] = AW'(l);
      reqStart = 1'b1;
      @(negedge clk);
      reqStart = 1'b0;
    end
    while (!finished) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares every round and every completion
  always @(negedge clk) begin
    if (rstN) begin
      if (doneLast) chk(reqReady == 1'b1, "R10", "ready after done", reqReady, 1);
      doneLast = done;
      if (roundValid) begin
        bit ok;
        chk(laneServed == expMask[rIdx], "R7", "round served mask", laneServed, expMask[rIdx]);
        ok = 1;
        for (int l = 0; l < NL; l++) begin
          if (laneServed[l]) begin
            int b0;
            int b1;
            b0 = int'(mAddr[l][4:0]);
            b1 = int'(5'(mAddr[l][4:0] + 5'd1));
            if (!bankEn[b0] || bankAddr[b0*AW +: AW] != mAddr[l] || int'(laneBank[l*5 +: 5]) != b0) ok = 0;
            if (mWide[l] && (!bankEn[b1] || bankAddr[b1*AW +: AW] != AW'(mAddr[l] + 1'b1))) ok = 0;
          end
        end
        chk(ok, "R9", "lane to bank map", laneServed, expMask[rIdx]);
        gotMask[rIdx] = laneServed;
        gotEn[rIdx]   = bankEn;
        gotBA[rIdx]   = bankAddr;
        rIdx++;
      end
      if (done) begin
        int e;
        e = (expCountQ.size() > 0) ? expCountQ.pop_front() : -1;
        chk(int'(roundCount) == e, "R10", "round count", roundCount, e);
        chk(rIdx == e, "R10", "rounds issued", rIdx, e);
        rIdx = 0;
        finished = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R0", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int l = 0; l < NL; l++) tAddr[l] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !roundValid && !done && bankEn == '0 && laneServed == '0,
        "R1", "reset state", {reqReady, roundValid, done}, 3'b100);

    // R2 stride-1
    tAct = '1; tWide = '0;
    for (int l = 0; l < NL; l++) tAddr[l] = AW'(96 + l);
    runReq(0);
    chk(gotEn[0] == '1, "R2", "stride-1 enables", gotEn[0], 32'hffffffff);
    chk(gotBA[0][5*AW +: AW] == AW'(101), "R2", "bank 5 word", gotBA[0][5*AW +: AW], 101);

    // R3 all lanes in bank 5, distinct words
    for (int l = 0; l < NL; l++) tAddr[l] = AW'(32*l + 5);
    runReq(0);
    chk(gotMask[31] == 32'h80000000, "R3", "last round lane", gotMask[31], 32'h80000000);

    // R4 broadcast
    for (int l = 0; l < NL; l++) tAddr[l] = AW'(77);
    runReq(0);
    chk(gotEn[0] == 32'h00002000, "R4", "broadcast bank", gotEn[0], 32'h00002000);
    chk(gotMask[0] == '1, "R4", "broadcast lanes", gotMask[0], 32'hffffffff);

    // R5 double word wrapping from bank 31 to 0
    tAct = 32'h1; tWide = 32'h1; tAddr[0] = AW'(31);
    runReq(0);
    chk(gotEn[0] == 32'h80000001, "R5", "wrap enables", gotEn[0], 32'h80000001);
    chk(gotBA[0][0 +: AW] == AW'(32), "R5", "upper word in bank 0", gotBA[0][0 +: AW], 32);

    // R6 single word equal to upper word shares, different word waits
    tAct = 32'h7; tWide = 32'h1;
    tAddr[0] = AW'(31); tAddr[1] = AW'(32); tAddr[2] = AW'(64);
    runReq(0);
    chk(gotMask[0] == 32'h3 && gotMask[1] == 32'h4, "R6", "shared upper word",
        {gotMask[1], gotMask[0]}, {32'h4, 32'h3});

    // R8 double word blocked by one busy bank
    tAct = 32'h3; tWide = 32'h2;
    tAddr[0] = AW'(33); tAddr[1] = AW'(0);
    runReq(0);
    chk(gotEn[0] == 32'h2, "R8", "only bank 1 first", gotEn[0], 2);
    chk(gotMask[1] == 32'h2, "R8", "wide lane second", gotMask[1], 2);

    // R7 lowest lane decides the bank word
    tAct = 32'h228; tWide = '0;
    tAddr[3] = AW'(64); tAddr[5] = AW'(32); tAddr[9] = AW'(64);
    runReq(0);
    chk(gotMask[0] == 32'h208, "R7", "lanes 3 and 9 first", gotMask[0], 32'h208);
    chk(gotBA[0][0 +: AW] == AW'(64), "R7", "bank 0 word", gotBA[0][0 +: AW], 64);

    // R12 inactive lanes with conflicting words are ignored
    tAct = 32'h10; tWide = '0;
    for (int l = 0; l < NL; l++) tAddr[l] = AW'(32*l);
    runReq(0);
    chk(gotMask[0] == 32'h10, "R12", "only active lane", gotMask[0], 32'h10);
    tAct = '0;
    runReq(0);

    // R11 start while busy is ignored
    tAct = '1; tWide = '0;
    for (int l = 0; l < NL; l++) tAddr[l] = AW'(32*l + 9);
    runReq(1);
    begin
      bit stray;
      stray = 0;
      repeat (4) begin
        @(negedge clk);
        if (roundValid || !reqReady) stray = 1;
      end
      chk(!stray, "R11", "no extra request", stray, 0);
    end

    // Mixed patterns against the model
    lfsr = 16'hACE1;
    for (int t = 0; t < 8; t++) begin
      for (int l = 0; l < NL; l++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tAddr[l] = AW'(lfsr[9:0] & (t[0] ? 10'h07f : 10'h3ff));
        tAct[l]  = lfsr[3] | lfsr[11];
        tWide[l] = lfsr[6] & lfsr[1];
      end
      runReq(0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule